// File: doc/BRIEF.md
# Programmable Divide Countdown Timer

This block is a local countdown timer for a processor-side interrupt source. A base tick enable is divided by a power-of-two prescaler, and a 32-bit counter steps down on each divided tick. The counter starts from a programmed start value. Three registers program the timer through a simple write port: a divider setting, a start value, and a control word. The control word holds the interrupt vector, a mask bit and a mode bit. The remaining count can be read at any time on a dedicated output.

In single-shot mode the count stops at zero. In repeating mode it reloads the start value on the divided tick after it reaches zero, which gives a period of the start value plus one divided ticks. Each time the count reaches zero the block raises a one-cycle interrupt request carrying the programmed vector, unless the mask bit is set. Address decode and interrupt routing belong to the surrounding logic.

Top module: `divtmr_top`

## Requirements
- R1: After reset the count output is 0 and irq_valid is low. The divider setting resets to 0 (divide by 2), and the control word resets to 0 (single-shot, unmasked, vector 0).
- R2: A write with wr_sel=0 stores only data bits 3, 1 and 0. The divider code is {bit3, bit1, bit0}, and the tick divisor is 2 to the power ((code+1) mod 8). Code 7 divides by 1, code 0 by 2 and code 6 by 128. Data bit 2 has no effect.
- R3: A write with wr_sel=1 sets the start value and the count to wr_data, visible on the next cycle. It also clears the prescaler, so the first divided tick comes after a full divisor of enabled ticks. A tick enable in the same cycle as this write is ignored.
- R4: In single-shot mode (control bit 17 = 0) the count drops by one per divided tick. It stays at 0 once reached.
- R5: In repeating mode (control bit 17 = 1), a divided tick while the count is 0 reloads the start value. The sequence repeats with a period of start value + 1 divided ticks.
- R6: When a divided tick takes the count from 1 to 0, irq_valid is high for exactly one cycle, the cycle in which the count first reads 0. In that cycle irq_vector equals control bits 7:0.
- R7: While control bit 16 (mask) is set, no interrupt request is raised, and counting continues unchanged.
- R8: A start value of 0 leaves the count at 0 with no reload and no interrupt request, in either mode.
- R9: A control write (wr_sel=2) changes mode and mask from the next divided tick onward, without restarting the count. A single-shot count stopped at 0 that is switched to repeating mode reloads on the next divided tick.
- R10: In cycles where tick_en is low, the count and the prescaler do not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Base tick enable feeding the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 divider, 1 start value, 2 control, 3 unused |
| wr_data | input | 32 | Write data |
| cur_count | output | 32 | Current remaining count |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
Some properties are checked by assertions on every cycle. The count moves only by a single decrement, a reload of the start value from zero in repeating mode, or a start-value write. A single-shot count at zero holds. A request appears only with the count at zero, never on two cycles in a row, and never while masked. A start value of zero keeps the timer idle. Other behaviour can only be shown by the bench's scenarios, which compare the count against a closed-form elapsed-tick formula: the divisor each divider code selects, the exact cycle of each request, the periodic reload interval, and the mode switch on a stopped timer.

// File: rtl/divtmr_pkg.sv
package divtmr_pkg;
  typedef enum logic [1:0] {
    SEL_DIV  = 2'd0,
    SEL_INIT = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  localparam int CTL_MASK_BIT = 16;
  localparam int CTL_PER_BIT  = 17;
  localparam int SHIFT_W      = 3;
endpackage

// File: rtl/divtmr_regs.sv
module divtmr_regs import divtmr_pkg::*; #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [CNT_W-1:0]   wr_data,
  output logic               load,
  output logic [CNT_W-1:0]   init_val,
  output logic [SHIFT_W-1:0] shift,
  output logic               periodic,
  output logic               masked,
  output logic [VEC_W-1:0]   vector
);
  logic [3:0]         div_cfg;
  logic [SHIFT_W-1:0] code;

  assign load  = wr_en && (wr_sel == SEL_INIT);
  assign code  = {div_cfg[3], div_cfg[1:0]};
  assign shift = code + 3'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cfg  <= '0;
      init_val <= '0;
      periodic <= 1'b0;
      masked   <= 1'b0;
      vector   <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_DIV:  div_cfg  <= wr_data[3:0] & 4'hB;
        SEL_INIT: init_val <= wr_data;
        SEL_CTL: begin
          vector   <= wr_data[VEC_W-1:0];
          masked   <= wr_data[CTL_MASK_BIT];
          periodic <= wr_data[CTL_PER_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/divtmr_prescale.sv
module divtmr_prescale import divtmr_pkg::*; #(
  parameter int PRE_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic               clear,
  input  logic [SHIFT_W-1:0] shift,
  output logic               dtick
);
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pmask;

  assign pmask = (PRE_W'(1) << shift) - PRE_W'(1);
  assign dtick = tick_en && !clear && ((pre_cnt & pmask) == pmask);

  always_ff @(posedge clk) begin
    if (rst || clear) pre_cnt <= '0;
    else if (tick_en) pre_cnt <= pre_cnt + PRE_W'(1);
  end
endmodule

// File: rtl/divtmr_count.sv
module divtmr_count #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dtick,
  input  logic             periodic,
  input  logic             masked,
  input  logic [CNT_W-1:0] init_val,
  input  logic [VEC_W-1:0] vector,
  output logic [CNT_W-1:0] count,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);
  logic armed;
  assign armed = (init_val != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= '0;
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid <= 1'b0;
      if (load) begin
        count <= load_val;
      end else if (dtick && armed) begin
        if (count != '0) begin
          count <= count - CNT_W'(1);
          if (count == CNT_W'(1) && !masked) begin
            irq_valid  <= 1'b1;
            irq_vector <= vector;
          end
        end else if (periodic) begin
          count <= init_val;
        end
      end
    end
  end
endmodule

// File: rtl/divtmr_top.sv
module divtmr_top import divtmr_pkg::*; #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8,
  parameter int PRE_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cur_count,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);
  logic               load;
  logic [CNT_W-1:0]   init_val;
  logic [SHIFT_W-1:0] shift;
  logic               ctl_periodic;
  logic               ctl_mask;
  logic [VEC_W-1:0]   ctl_vector;
  logic               dtick;

  divtmr_regs #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .load(load), .init_val(init_val), .shift(shift),
    .periodic(ctl_periodic), .masked(ctl_mask), .vector(ctl_vector)
  );

  divtmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .tick_en(tick_en), .clear(load),
    .shift(shift), .dtick(dtick)
  );

  divtmr_count #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(wr_data), .dtick(dtick),
    .periodic(ctl_periodic), .masked(ctl_mask), .init_val(init_val),
    .vector(ctl_vector), .count(cur_count), .irq_valid(irq_valid),
    .irq_vector(irq_vector)
  );
endmodule

// File: rtl/divtmr_chk.sv
module divtmr_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] cur_count,
  input logic             irq_valid,
  input logic             mask_q,
  input logic             per_q,
  input logic [CNT_W-1:0] init_q
);
  logic             seen;
  logic             p_wr, p_load, p_mask, p_per;
  logic [CNT_W-1:0] p_cnt, p_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 1'b0;
      p_wr <= 1'b0; p_load <= 1'b0; p_mask <= 1'b0; p_per <= 1'b0;
      p_cnt <= '0; p_data <= '0;
    end else begin
      seen   <= 1'b1;
      p_wr   <= wr_en;
      p_load <= wr_en && (wr_sel == 2'd1);
      p_mask <= mask_q;
      p_per  <= per_q;
      p_cnt  <= cur_count;
      p_data <= wr_data;
    end
  end

  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (cur_count == '0)); // R6
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq_valid |=> !irq_valid); // R6
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (seen && p_load) |-> (cur_count == p_data)); // R3
  AST_STEP_OR_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (seen && !p_wr && cur_count != p_cnt) |->
      ((cur_count == p_cnt - CNT_W'(1)) || (p_cnt == '0 && p_per && cur_count == init_q))); // R5
  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (seen && !p_wr && !p_per && p_cnt == '0) |-> (cur_count == '0)); // R4
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (seen && p_mask) |-> !irq_valid); // R7
  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (init_q == '0) |-> (cur_count == '0 && !irq_valid)); // R8
endmodule

bind divtmr_top divtmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .cur_count(cur_count), .irq_valid(irq_valid), .mask_q(ctl_mask),
  .per_q(ctl_periodic), .init_q(init_val)
);

// File: tb/divtmr_top_test.sv
module divtmr_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] cur_count;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // model state
  longint m_init = 0, m_e = 0, m_div = 2;
  bit     m_per = 0, m_mask = 0;
  logic [7:0] m_vec = 0;

  always #2.5 clk = ~clk;

  divtmr_top uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cur_count(cur_count), .irq_valid(irq_valid),
    .irq_vector(irq_vector)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint div_of(input logic [31:0] d);
    logic [2:0] code;
    code = {d[3], d[1:0]};
    return longint'(1) << ((int'(code) + 1) % 8);
  endfunction

  function automatic longint exp_count();
    longint d;
    if (m_init == 0) return 0;
    d = m_e / m_div;
    if (m_per) return m_init - (d % (m_init + 1));
    return (d >= m_init) ? 0 : m_init - d;
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [31:0] data, input bit t);
    wr_en = 1'b1; wr_sel = sel; wr_data = data; tick_en = t;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
    case (sel)
      2'd0: m_div = div_of(data);
      2'd1: begin m_init = data; m_e = 0; end
      2'd2: begin m_vec = data[7:0]; m_mask = data[16]; m_per = data[17]; end
      default: ;
    endcase
    if (sel == 2'd1) chk(cur_count == data, "R3 load", cur_count, data);
  endtask

  task automatic run(input int n, input int pct, input string tag);
    for (int i = 0; i < n; i++) begin
      bit t;
      bit fire;
      longint d;
      t = ($urandom_range(99) < pct);
      fire = 0;
      tick_en = t;
      @(posedge clk);
      if (t) begin
        m_e++;
        if (m_init != 0 && (m_e % m_div) == 0) begin
          d = m_e / m_div;
          fire = (m_per ? ((d % (m_init + 1)) == m_init) : (d == m_init)) && !m_mask;
        end
      end
      @(negedge clk);
      tick_en = 1'b0;
      chk(cur_count == 32'(exp_count()), {tag, " count"}, cur_count, exp_count());
      chk(irq_valid == fire, {tag, " R6 irq"}, irq_valid, fire);
      if (fire) chk(irq_vector == m_vec, {tag, " R6 vector"}, irq_vector, m_vec);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(cur_count == 0, "R1 count", cur_count, 0);
    chk(irq_valid == 0, "R1 irq", irq_valid, 0);
    wr(2'd1, 32'd5, 1'b0);
    run(12, 100, "R1 default div2 oneshot");

    // R2 bit 2 ignored: 0x4 keeps divide by 2; 0xF gives divide by 1
    wr(2'd0, 32'h4, 1'b0);
    wr(2'd2, 32'h0000_0033, 1'b0);
    wr(2'd1, 32'd4, 1'b1);
    chk(m_div == 2, "R2 divisor model", m_div, 2);
    run(10, 100, "R2 bit2 ignored");
    wr(2'd0, 32'hF, 1'b0);
    wr(2'd1, 32'd3, 1'b1);
    run(6, 100, "R2 code7 div1");

    // R5 periodic with div1, R10 idle ticks
    wr(2'd2, 32'h0002_0055, 1'b0);
    wr(2'd1, 32'd2, 1'b0);
    run(12, 100, "R5 periodic");
    run(10, 0, "R10 no tick");

    // R7 masked periodic
    wr(2'd2, 32'h0003_0066, 1'b0);
    wr(2'd1, 32'd3, 1'b0);
    run(20, 100, "R7 masked");

    // R8 zero start value, both modes
    wr(2'd1, 32'd0, 1'b0);
    run(15, 100, "R8 zero periodic");
    wr(2'd2, 32'h0000_0011, 1'b0);
    run(15, 100, "R8 zero oneshot");

    // R9 switch stopped single-shot timer to repeating
    wr(2'd0, 32'hB, 1'b0);
    wr(2'd2, 32'h0000_0021, 1'b0);
    wr(2'd1, 32'd3, 1'b0);
    run(6, 100, "R4 oneshot stop");
    wr(2'd2, 32'h0002_0021, 1'b0);
    chk(cur_count == 0, "R9 no restart", cur_count, 0);
    tick_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
    chk(cur_count == 3, "R9 reload after switch", cur_count, 3);
    chk(irq_valid == 0, "R9 no irq on reload", irq_valid, 0);

    // random scenarios
    for (int s = 0; s < 14; s++) begin
      logic [2:0]  code;
      logic [31:0] ctl;
      code = 3'($urandom_range(7));
      wr(2'd0, {28'd0, code[2], 1'($urandom_range(1)), code[1:0]}, 1'b0);
      ctl = {14'd0, 1'($urandom_range(1)), 1'($urandom_range(3) == 0), 8'd0, 8'($urandom_range(255))};
      wr(2'd2, ctl, 1'b0);
      wr(2'd1, 32'($urandom_range(1, 12)), 1'($urandom_range(1)));
      run(250, 75, "R4 R5 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule